// File: doc/BRIEF.md
# Programmable Core Clock Divider with Processor Clock Forwarding

This block takes the crystal-rate master clock and derives the slower core timebase from it. It divides by a ratio K. K comes from a 4-bit control field and can take any value from 1 to 16. A field of zero selects the largest ratio. The divided rate is meant to land near 4 MHz, so a faster crystal is handled by choosing a larger K.

The block has two divided outputs. The first is a one-cycle enable that logic in the master domain uses to advance at the core rate. The second is a divided clock with close to 50% duty. A new ratio is applied only at the end of the current output period, so no period is ever cut short.

The block also sends a copy of the master clock to an external processor. By default this copy is the inverse of the master clock. A polarity bit removes the inversion when the other clock phase is quieter for the board.

Top module: `core_clk_divider`

## Requirements
- R1: With a ratio field of 1 to 15, `div_en_o` is high for exactly one master cycle in every K master cycles, where K equals the field value.
- R2: A ratio field of 0 gives a divide ratio of 16, so the enable pulses once in every 16 master cycles.
- R3: With K = 1, `div_en_o` stays high on every master cycle, and `div_clk_o` follows the master clock level.
- R4: For K of 2 or more, `div_clk_o` is high for floor(K/2) master cycles and low for the other K - floor(K/2) cycles. Its high phase starts in the same cycle as the enable pulse.
- R5: A new value on the ratio field does not change the period in progress. It becomes the ratio for the period that starts after the next terminal count.
- R6: While reset is low (sampled at the master clock edge), the divide counter is cleared and `div_en_o` is low. After reset is released with ratio K, the first enable pulse appears K master cycles later.
- R7: With `cpu_noinv_i` low, `cpu_clk_o` is the logical inverse of the master clock.
- R8: With `cpu_noinv_i` high, `cpu_clk_o` equals the master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Crystal-rate master clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| ratio_i | input | 4 | Divide ratio field; 0 selects 16 |
| cpu_noinv_i | input | 1 | 1 = forward master clock without inversion |
| div_en_o | output | 1 | One-cycle enable at master/K |
| div_clk_o | output | 1 | Divided clock, high floor(K/2) cycles per period |
| cpu_clk_o | output | 1 | Master clock forwarded to the processor |

## Verification
The hardest case to reach from the ports is a ratio change that arrives in the middle of a period. The new value must be held back until the counter wraps. To do this, the stimulus follows a model counter and writes the new field value only when the model is one cycle into a period. The scoreboard then expects the remaining cycles of the old ratio before the new one takes over. The K = 1 bypass also needs care, because the divided clock then has the master clock's own shape. The bench samples it during the high half of the master clock as well as at the falling edge.

// File: rtl/clkdiv_pkg.sv
// Package: shared defaults and types for the core clock divider.
// Assumes: ratio fields are unsigned and an all-zero field means the maximum ratio.
package clkdiv_pkg;

    // Default width of the ratio field.
    localparam int unsigned DEF_RATIO_W = 4;

    // Polarity choice for the forwarded processor clock.
    typedef enum logic {
        POL_INVERTED = 1'b0,
        POL_DIRECT   = 1'b1
    } cpu_pol_e;

endpackage

// File: rtl/clkdiv_ratio_map.sv
// Module: maps the raw ratio field to the effective divide ratio K.
// Assumes: a zero field means 2**RATIO_W; every other value is used as is.
module clkdiv_ratio_map #(
    parameter int unsigned RATIO_W = clkdiv_pkg::DEF_RATIO_W
) (
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [RATIO_W:0]   k_o
);
    localparam int unsigned K_W = RATIO_W + 1;
    localparam logic [K_W-1:0] K_MAX_V = {1'b1, {RATIO_W{1'b0}}};

    // Decode the field; zero is the top ratio.
    always_comb begin
        k_o = {1'b0, ratio_i};
        if (ratio_i == '0) begin
            k_o = K_MAX_V;
        end
    end
endmodule

// File: rtl/clkdiv_period_ctr.sv
// Module: period counter that counts 0..K-1 and pulses the enable on wrap.
// Assumes: K is sampled only at the terminal count or during reset, so a
// period in progress always runs to its full length.
module clkdiv_period_ctr #(
    parameter int unsigned RATIO_W = clkdiv_pkg::DEF_RATIO_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W:0]   k_map_i,
    output logic [RATIO_W-1:0] cnt_q,
    output logic [RATIO_W:0]   k_q,
    output logic               en_q,
    output logic [RATIO_W-1:0] cnt_d,
    output logic [RATIO_W:0]   k_d,
    output logic               wrap_o
);
    localparam int unsigned K_W = RATIO_W + 1;

    logic en_d;

    // Terminal count: the counter has reached K-1.
    assign wrap_o = ({1'b0, cnt_q} == (k_q - K_W'(1)));

    // Next-state values, including reset, shared with the phase generator.
    always_comb begin
        if (!rst_ni) begin
            cnt_d = '0;
            k_d   = k_map_i;
            en_d  = 1'b0;
        end else if (wrap_o) begin
            cnt_d = '0;
            k_d   = k_map_i;
            en_d  = 1'b1;
        end else begin
            cnt_d = cnt_q + RATIO_W'(1);
            k_d   = k_q;
            en_d  = 1'b0;
        end
    end

    // Counter, active ratio and enable registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            k_q   <= k_map_i;
            en_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            k_q   <= k_d;
            en_q  <= en_d;
        end
    end
endmodule

// File: rtl/clkdiv_phase_gen.sv
// Module: builds the divided clock from the counter's next state.
// Assumes: the high phase covers counts 0..floor(K/2)-1. For K = 1 the
// master clock is passed through when the bypass option is on.
module clkdiv_phase_gen #(
    parameter int unsigned RATIO_W   = clkdiv_pkg::DEF_RATIO_W,
    parameter bit          K1_BYPASS = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W-1:0] cnt_d,
    input  logic [RATIO_W:0]   k_d,
    input  logic [RATIO_W:0]   k_q,
    output logic               div_clk_o
);
    localparam int unsigned K_W = RATIO_W + 1;

    logic           div_q;
    logic [K_W-1:0] half_d;
    logic           high_d;

    // The high phase lasts floor(K/2) counts.
    always_comb begin
        half_d = k_d >> 1;
        high_d = ({1'b0, cnt_d} < half_d);
    end

    // Phase register; on reset it takes the value for count zero.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_q <= high_d;
        end else begin
            div_q <= high_d;
        end
    end

    generate
        if (K1_BYPASS) begin : g_bypass
            // Divide-by-one passes the master clock straight through.
            assign div_clk_o = (k_q == K_W'(1)) ? clk_i : div_q;
        end else begin : g_reg_only
            // Registered phase only.
            assign div_clk_o = div_q;
        end
    endgenerate
endmodule

// File: rtl/clkdiv_cpu_fwd.sv
// Module: forwards the master clock to the processor with a selectable polarity.
// Assumes: the polarity is static while the processor runs, so no glitch
// protection is provided.
module clkdiv_cpu_fwd (
    input  logic                 clk_i,
    input  clkdiv_pkg::cpu_pol_e pol_i,
    output logic                 cpu_clk_o
);
    // Choose between the true and the inverted master clock.
    always_comb begin
        if (pol_i == clkdiv_pkg::POL_DIRECT) begin
            cpu_clk_o = clk_i;
        end else begin
            cpu_clk_o = ~clk_i;
        end
    end
endmodule

// File: rtl/core_clk_divider.sv
// Module: top of the core clock divider. It produces an enable and a clock at
// master/K, and forwards the master clock to the processor.
// Assumes: a synchronous active-low reset in the master clock domain.
module core_clk_divider #(
    parameter int unsigned RATIO_W = clkdiv_pkg::DEF_RATIO_W
) (
    input  logic               mclk_i,
    input  logic               rst_n_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               cpu_noinv_i,
    output logic               div_en_o,
    output logic               div_clk_o,
    output logic               cpu_clk_o
);
    logic [RATIO_W:0]   k_map;
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W:0]   k_q;
    logic [RATIO_W-1:0] cnt_d;
    logic [RATIO_W:0]   k_d;
    logic               wrap;

    clkdiv_ratio_map #(.RATIO_W(RATIO_W)) u_map (
        .ratio_i (ratio_i),
        .k_o     (k_map)
    );

    clkdiv_period_ctr #(.RATIO_W(RATIO_W)) u_ctr (
        .clk_i   (mclk_i),
        .rst_ni  (rst_n_i),
        .k_map_i (k_map),
        .cnt_q   (cnt_q),
        .k_q     (k_q),
        .en_q    (div_en_o),
        .cnt_d   (cnt_d),
        .k_d     (k_d),
        .wrap_o  (wrap)
    );

    clkdiv_phase_gen #(.RATIO_W(RATIO_W), .K1_BYPASS(1'b1)) u_phase (
        .clk_i     (mclk_i),
        .rst_ni    (rst_n_i),
        .cnt_d     (cnt_d),
        .k_d       (k_d),
        .k_q       (k_q),
        .div_clk_o (div_clk_o)
    );

    clkdiv_cpu_fwd u_cpu (
        .clk_i     (mclk_i),
        .pol_i     (clkdiv_pkg::cpu_pol_e'(cpu_noinv_i)),
        .cpu_clk_o (cpu_clk_o)
    );
endmodule

// File: rtl/clkdiv_checker.sv
// Module: assertion checker bound to core_clk_divider.
// Assumes: it sees the active ratio, the counter and the terminal count through the bind.
module clkdiv_checker #(
    parameter int unsigned RATIO_W = clkdiv_pkg::DEF_RATIO_W
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [RATIO_W-1:0] ratio_i,
    input logic               div_en_o,
    input logic               div_clk_o,
    input logic [RATIO_W:0]   k_active,
    input logic [RATIO_W-1:0] cnt_q,
    input logic               wrap
);
    localparam int unsigned K_W   = RATIO_W + 1;
    localparam int unsigned GAP_W = K_W + 1;
    localparam logic [K_W-1:0] K_MAX_V = {1'b1, {RATIO_W{1'b0}}};

    logic [GAP_W-1:0] gap;
    logic [K_W-1:0]   per_k;
    logic             have;

    // Count the cycles since the last enable and remember that period's ratio.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gap   <= '0;
            per_k <= '0;
            have  <= 1'b0;
        end else if (div_en_o) begin
            gap   <= GAP_W'(1);
            per_k <= k_active;
            have  <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + GAP_W'(1);
        end
    end

    AST_EN_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_en_o && have) |-> ({1'b0, per_k} == gap)); // R1

    AST_ZERO_SEL_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap && ratio_i == '0) |=> (k_active == K_MAX_V)); // R2

    AST_K1_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (k_active == K_W'(1)) |=> div_en_o); // R3

    AST_EN_HIGH_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_en_o && k_active >= K_W'(2)) |-> div_clk_o); // R4

    AST_K_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> $stable(k_active)); // R5

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |=> (!div_en_o && cnt_q == '0)); // R6
endmodule

bind core_clk_divider clkdiv_checker #(.RATIO_W(RATIO_W)) u_chk (
    .clk_i     (mclk_i),
    .rst_ni    (rst_n_i),
    .ratio_i   (ratio_i),
    .div_en_o  (div_en_o),
    .div_clk_o (div_clk_o),
    .k_active  (k_q),
    .cnt_q     (cnt_q),
    .wrap      (wrap)
);

// File: tb/tb_core_clk_divider.sv
// Bench: a driver pushes the expected enable and divided-clock levels into a
// queue after each master edge, and a monitor pops and compares them at the
// falling edge. Direct checks cover the clock-level outputs.
module tb_core_clk_divider;
    typedef struct {
        logic  en;
        logic  dv;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ratio = 4'd5;
    logic       noinv = 1'b0;
    logic       div_en, div_clk, cpu_clk;

    int    n_chk = 0;
    int    n_err = 0;
    int    m_cnt = 0;
    int    m_k = 5;
    string cur_tag = "R6";
    item_t sb[$];

    always #5 clk = ~clk;

    core_clk_divider dut (
        .mclk_i      (clk),
        .rst_n_i     (rst_n),
        .ratio_i     (ratio),
        .cpu_noinv_i (noinv),
        .div_en_o    (div_en),
        .div_clk_o   (div_clk),
        .cpu_clk_o   (cpu_clk)
    );

    function automatic int dec(input logic [3:0] r);
        return (r == 4'd0) ? 16 : int'(r);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Driver: wait for a master edge, advance the expected period, push the expected item.
    task automatic step();
        item_t it;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_cnt = 0; m_k = dec(ratio); it.en = 1'b0;
        end else if (m_cnt == m_k - 1) begin
            m_cnt = 0; m_k = dec(ratio); it.en = 1'b1;
        end else begin
            m_cnt++; it.en = 1'b0;
        end
        it.dv  = (m_k == 1) ? 1'b0 : (m_cnt < m_k / 2);
        it.tag = cur_tag;
        sb.push_back(it);
    endtask

    // Monitor: compare the outputs at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, div_en, it.en, "div_en_o");
                check(it.tag, div_clk, it.dv, "div_clk_o");
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        // R6: reset holds the enable low; the first pulse comes K cycles after release.
        cur_tag = "R6";
        repeat (3) step();
        rst_n = 1'b1;
        repeat (5) step();
        // R1: steady divide by 5.
        cur_tag = "R1";
        repeat (20) step();
        // R5: change the ratio one cycle into a period.
        cur_tag = "R5";
        while (m_cnt != 1) step();
        ratio = 4'd3;
        repeat (24) step();
        // R4: odd ratio 7 and even ratio 8, checking duty.
        cur_tag = "R4";
        ratio = 4'd7;
        repeat (30) step();
        ratio = 4'd8;
        repeat (30) step();
        // R2: a zero field divides by 16.
        cur_tag = "R2";
        ratio = 4'd0;
        repeat (50) step();
        // R3: divide by one; the divided clock follows the master clock.
        cur_tag = "R3";
        ratio = 4'd1;
        for (int i = 0; i < 20 && m_k != 1; i++) step();
        for (int i = 0; i < 6; i++) begin
            step();
            #1;
            check("R3", div_clk, 1'b1, "div_clk_o during master high");
        end
        // R1: ratios 2 and 15.
        cur_tag = "R1";
        ratio = 4'd2;
        repeat (12) step();
        ratio = 4'd15;
        repeat (35) step();
        // R7: inverted processor clock.
        noinv = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            #1;
            check("R7", cpu_clk, 1'b0, "cpu_clk_o master high");
            #5;
            check("R7", cpu_clk, 1'b1, "cpu_clk_o master low");
        end
        // R8: direct processor clock.
        noinv = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            #1;
            check("R8", cpu_clk, 1'b1, "cpu_clk_o master high");
            #5;
            check("R8", cpu_clk, 1'b0, "cpu_clk_o master low");
        end
        // R6: reset in the middle of a run, then release with ratio 4.
        cur_tag = "R6";
        ratio = 4'd4;
        rst_n = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        repeat (14) step();
        @(negedge clk);
        #1;
        summary();
    end
endmodule